// File: doc/BRIEF.md
# Serial ADC Readout Output Sequencer

This block produces the digital output side of a serial converter during a data read cycle. When a read request is accepted, it captures one conversion result. It then shifts the result out MSB first on a single serial data line, timed by the rising edges of the output clock. Around the data it drives three more signals: a frame-sync line, an output-enable that stands in for the high-impedance state of the data and sync pins, and a bus-busy flag. The bus-busy flag tells other devices on a shared link when they may use it.

A mode pin sets the order of the end-of-frame events. In daisy-chain mode the bus-busy flag drops while the outputs are still driven, a set number of edges before sync rises. In cascade mode it drops only after the outputs have gone to high impedance. The block keeps two result registers, a previous one and a current one. A read that starts early in a conversion returns the previous result, and a read that starts after the forbidden window returns the current result. A read request that lands inside the window is deferred until the window closes and is flagged with a one-cycle pulse. The window bounds are runtime inputs, counted in clock cycles from the conversion start.

Top module: `adc_readout_seq`

## Requirements
- R1: After reset, oe_o, sdo_o, sync_o, bus_busy_o and read_viol_o are all 0.
- R2: On the edge that accepts a read, oe_o and bus_busy_o go to 1 and sync_o stays 0. Edges after that edge are numbered 1, 2, 3 and so on.
- R3: After edge 1, sdo_o is 0. After edge k, for k from 2 to DATA_W+1, sdo_o holds bit DATA_W+1-k of the captured word, so the MSB appears after edge 2 and the LSB after edge 17.
- R4: On edge DATA_W+2 (edge 18), oe_o falls. Whenever oe_o is 0, sdo_o and sync_o read 0 (high impedance).
- R5: In both modes, sync_o rises on edge DATA_W (edge 16) and stays high until edge 18.
- R6: Daisy-chain mode is mode_i = 0. In this mode bus_busy_o falls on edge DATA_W-SYNC_LEAD (edge 15), while oe_o is still 1.
- R7: Cascade mode is mode_i = 1. In this mode bus_busy_o falls on edge DATA_W+2+OFF_TAIL (edge 19), after oe_o has already fallen.
- R8: A read request arrives while the conversion counter c satisfies win_lo_i <= c < win_hi_i. The counter is 0 after the conv_start_i edge, increments each cycle and saturates at win_hi_i. For such a request, read_viol_o is 1 for exactly one cycle, and the frame starts on the first edge at which c is no longer inside the window.
- R9: A read that starts while c < win_lo_i transmits the previous result. This is the value the current register held when conv_start_i was sampled. A read that starts after the window transmits the current result, which is the last conv_data_i loaded by conv_done_i.
- R10: The word to transmit is captured at frame start. A conv_done_i during a frame does not alter the bits being shifted.
- R11: A read request that arrives while a frame is in progress is ignored. No later frame results from it.
- R12: mode_i is sampled at frame start. A change of mode_i during a frame does not alter that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock; all events occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0 = daisy-chain, 1 = cascade; sampled at frame start |
| win_lo_i | input | CNT_W | Window start, in cycles after conversion start |
| win_hi_i | input | CNT_W | Window end (exclusive), in cycles after conversion start |
| conv_start_i | input | 1 | Conversion start pulse; moves current result to previous |
| conv_done_i | input | 1 | Conversion result valid pulse |
| conv_data_i | input | DATA_W | Conversion result |
| read_req_i | input | 1 | Read-cycle request pulse |
| sdo_o | output | 1 | Serial data, MSB first |
| sync_o | output | 1 | Frame sync |
| oe_o | output | 1 | Output enable for sdo_o and sync_o; 0 means high impedance |
| bus_busy_o | output | 1 | Shared-link busy flag |
| read_viol_o | output | 1 | One-cycle pulse for a request deferred by the window |

## Verification
The bench builds the block with its default parameters: DATA_W of 16, SYNC_LEAD of 1 and OFF_TAIL of 1. These values put every edge the requirements name (2, 15, 16, 17, 18 and 19) inside a 20-edge frame. The window inputs are set to 4 and 8, so a request can be placed before, inside or after the window within a few cycles of a conversion start, and the deferred start edge can be predicted exactly. Frames are run in both modes, with result patterns that place ones at the MSB and the LSB.

// File: rtl/ros_pkg.sv
// Shared types for the readout sequencer.
package ros_pkg;
    // Selects the ordering of bus release at the end of a frame.
    typedef enum logic {
        MODE_DAISY   = 1'b0,
        MODE_CASCADE = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/ros_window.sv
// Tracks cycles since the last conversion start and reports whether the
// present cycle lies before or inside the forbidden read-start window.
// Assumes win_lo_i <= win_hi_i and that both stay steady during a conversion.
module ros_window #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_i,
    input  logic [CNT_W-1:0] win_lo_i,
    input  logic [CNT_W-1:0] win_hi_i,
    output logic             before_o,
    output logic             inside_o
);
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    // Restart the count on a conversion start and saturate it at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (conv_start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q && cnt_q < win_hi_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Classify the present cycle against the window bounds.
    always_comb begin
        before_o = run_q && (cnt_q < win_lo_i);
        inside_o = run_q && (cnt_q >= win_lo_i) && (cnt_q < win_hi_i);
    end

    a_r8_window_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        inside_o |-> !before_o);
endmodule

// File: rtl/ros_results.sv
// Holds the previous and current conversion results and selects one of them.
// A conversion start moves current into previous; a done pulse loads current.
module ros_results #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start_i,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic              use_prev_i,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] prev_q;
    logic [DATA_W-1:0] cur_q;

    // Age the current result on a start; load a fresh one on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            cur_q  <= '0;
        end else begin
            if (conv_start_i) prev_q <= cur_q;
            if (conv_done_i)  cur_q  <= conv_data_i;
        end
    end

    // Pick the register the next frame should carry.
    always_comb word_o = use_prev_i ? prev_q : cur_q;
endmodule

// File: rtl/ros_frame.sv
// Runs one read frame: captures the word and the mode at start, shifts the
// data MSB first from edge 2, raises sync and turns the outputs off at fixed
// edges, and drops bus-busy at the edge the latched mode calls for.
// Assumes start_i is only raised while act_o is low.
module ros_frame
    import ros_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SYNC_LEAD = 1,
    parameter int OFF_TAIL  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] word_i,
    input  rd_mode_e          mode_i,
    output logic              act_o,
    output logic              oe_o,
    output logic              sdo_o,
    output logic              sync_o,
    output logic              busy_o
);
    localparam int LAST_N = DATA_W + 2 + OFF_TAIL;
    localparam int EC_W   = $clog2(LAST_N + 1) + 1;
    localparam logic [EC_W-1:0] E_MSB    = EC_W'(2);
    localparam logic [EC_W-1:0] E_LSB    = EC_W'(DATA_W + 1);
    localparam logic [EC_W-1:0] E_SYNC   = EC_W'(DATA_W);
    localparam logic [EC_W-1:0] E_OFF    = EC_W'(DATA_W + 2);
    localparam logic [EC_W-1:0] E_FALL_D = EC_W'(DATA_W - SYNC_LEAD);
    localparam logic [EC_W-1:0] E_FALL_C = EC_W'(LAST_N);

    logic              act_q, oe_q, sdo_q, sync_q, busy_q;
    logic [EC_W-1:0]   ec_q;
    logic [DATA_W-1:0] sh_q;
    rd_mode_e          mode_q;
    logic [EC_W-1:0]   n;
    logic [EC_W-1:0]   fall_n;
    logic [EC_W-1:0]   last_n;

    // Number of the coming edge and the per-mode release and end edges.
    always_comb begin
        n      = ec_q + 1'b1;
        fall_n = (mode_q == MODE_CASCADE) ? E_FALL_C : E_FALL_D;
        last_n = (mode_q == MODE_CASCADE) ? E_FALL_C : E_OFF;
    end

    // Frame state machine keyed on the edge count since start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            oe_q   <= 1'b0;
            sdo_q  <= 1'b0;
            sync_q <= 1'b0;
            busy_q <= 1'b0;
            ec_q   <= '0;
            sh_q   <= '0;
            mode_q <= MODE_DAISY;
        end else if (start_i) begin
            act_q  <= 1'b1;
            oe_q   <= 1'b1;
            busy_q <= 1'b1;
            sdo_q  <= 1'b0;
            sync_q <= 1'b0;
            ec_q   <= '0;
            sh_q   <= word_i;
            mode_q <= mode_i;
        end else if (act_q) begin
            ec_q <= n;
            if (n >= E_MSB && n <= E_LSB) begin
                sdo_q <= sh_q[DATA_W-1];
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            end
            if (n == E_SYNC) sync_q <= 1'b1;
            if (n == E_OFF) begin
                oe_q   <= 1'b0;
                sdo_q  <= 1'b0;
                sync_q <= 1'b0;
            end
            if (n == fall_n) busy_q <= 1'b0;
            if (n == last_n) act_q  <= 1'b0;
        end
    end

    assign act_o  = act_q;
    assign oe_o   = oe_q;
    assign sdo_o  = sdo_q;
    assign sync_o = sync_q;
    assign busy_o = busy_q;

    a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_q |-> (!sdo_q && !sync_q));
    a_r5_sync_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> oe_q);
    a_r6_daisy_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && mode_q == MODE_DAISY) |-> (oe_q && !sync_q));
    a_r7_cascade_late_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && mode_q == MODE_CASCADE) |-> (!oe_q && $past(!oe_q)));
    a_r12_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |=> $stable(mode_q));
endmodule

// File: rtl/adc_readout_seq.sv
// Top of the readout sequencer. Accepts read requests, defers those that
// land in the forbidden window (pulsing a violation flag), picks the
// previous or current result and hands it to the frame engine.
// Assumes one request pulse per intended read.
module adc_readout_seq
    import ros_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int SYNC_LEAD = 1,
    parameter int OFF_TAIL  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic [CNT_W-1:0]  win_lo_i,
    input  logic [CNT_W-1:0]  win_hi_i,
    input  logic              conv_start_i,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic              read_req_i,
    output logic              sdo_o,
    output logic              sync_o,
    output logic              oe_o,
    output logic              bus_busy_o,
    output logic              read_viol_o
);
    logic              before_w, inside_w, act_w, start_w;
    logic              pend_q, viol_q;
    logic [DATA_W-1:0] word_w;

    ros_window #(.CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start_i),
        .win_lo_i(win_lo_i), .win_hi_i(win_hi_i),
        .before_o(before_w), .inside_o(inside_w)
    );

    ros_results #(.DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start_i),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .use_prev_i(before_w), .word_o(word_w)
    );

    // A frame starts for a live or held request once outside the window.
    always_comb start_w = (read_req_i || pend_q) && !inside_w && !act_w;

    // Hold a request made inside the window and flag it once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            viol_q <= 1'b0;
        end else begin
            viol_q <= read_req_i && inside_w && !pend_q && !act_w;
            if (start_w)
                pend_q <= 1'b0;
            else if (read_req_i && inside_w && !act_w)
                pend_q <= 1'b1;
        end
    end

    ros_frame #(.DATA_W(DATA_W), .SYNC_LEAD(SYNC_LEAD), .OFF_TAIL(OFF_TAIL)) u_frm (
        .clk(clk), .rst_n(rst_n), .start_i(start_w), .word_i(word_w),
        .mode_i(rd_mode_e'(mode_i)), .act_o(act_w), .oe_o(oe_o),
        .sdo_o(sdo_o), .sync_o(sync_o), .busy_o(bus_busy_o)
    );

    assign read_viol_o = viol_q;

    a_r8_viol_single: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |=> !viol_q);
    a_r8_no_start_inside: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> !$past(inside_w));
    a_r2_start_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> (bus_busy_o && !sync_o));
endmodule

// File: tb/sim_adc_readout_seq.sv
module sim_adc_readout_seq;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic [7:0]  win_lo_i = 8'd4;
    logic [7:0]  win_hi_i = 8'd8;
    logic        conv_start_i = 1'b0;
    logic        conv_done_i = 1'b0;
    logic [15:0] conv_data_i = '0;
    logic        read_req_i = 1'b0;
    logic        sdo_o, sync_o, oe_o, bus_busy_o, read_viol_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    adc_readout_seq u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .win_lo_i(win_lo_i),
        .win_hi_i(win_hi_i), .conv_start_i(conv_start_i), .conv_done_i(conv_done_i),
        .conv_data_i(conv_data_i), .read_req_i(read_req_i), .sdo_o(sdo_o),
        .sync_o(sync_o), .oe_o(oe_o), .bus_busy_o(bus_busy_o),
        .read_viol_o(read_viol_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One rising edge, then settle away from it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Next edge starts a frame; checks edges 0..19 against the requirements.
    task automatic check_frame(input logic [15:0] w, input logic m, input string tag,
                               input int poke_n, input logic [15:0] poke_d);
        for (int n = 0; n < 20; n++) begin
            tick();
            read_req_i  = 1'b0;
            conv_done_i = 1'b0;
            chk({tag, " R2/R4 oe"}, oe_o, (n < 18));
            chk({tag, " R5 sync"}, sync_o, (n >= 16 && n < 18));
            chk({tag, " R3 sdo"}, sdo_o, (n >= 2 && n <= 17) ? w[17-n] : 1'b0);
            if (m) chk({tag, " R7 busy"}, bus_busy_o, (n < 19));
            else   chk({tag, " R6 busy"}, bus_busy_o, (n < 15));
            if (n == poke_n) begin
                conv_done_i = 1'b1;
                conv_data_i = poke_d;
                read_req_i  = 1'b1;
                mode_i      = ~mode_i;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        chk("R1 reset oe", oe_o, 0);
        chk("R1 reset sdo", sdo_o, 0);
        chk("R1 reset sync", sync_o, 0);
        chk("R1 reset busy", bus_busy_o, 0);
        chk("R1 reset viol", read_viol_o, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic load(input logic [15:0] d);
        conv_done_i = 1'b1; conv_data_i = d;
        tick();
        conv_done_i = 1'b0;
    endtask

    task automatic t_daisy();
        load(16'hA5C3);
        mode_i = 1'b0; read_req_i = 1'b1;
        check_frame(16'hA5C3, 1'b0, "daisy", -1, '0);
    endtask

    task automatic t_cascade();
        load(16'h8001);
        mode_i = 1'b1; read_req_i = 1'b1;
        check_frame(16'h8001, 1'b1, "cascade", -1, '0);
        mode_i = 1'b0;
    endtask

    task automatic t_prev_cur();
        load(16'h1111);
        conv_start_i = 1'b1;
        tick();                       // edge C, count 0
        conv_start_i = 1'b0;
        load(16'h2222);               // edge C+1
        read_req_i = 1'b1;            // sampled at C+2, count 2 < lo
        check_frame(16'h1111, 1'b0, "R9 prev", -1, '0);
        read_req_i = 1'b1;            // window long past
        check_frame(16'h2222, 1'b0, "R9 cur", -1, '0);
    endtask

    task automatic t_window();
        conv_start_i = 1'b1;
        tick();                       // edge C
        conv_start_i = 1'b0;
        tick();                       // C+1
        load(16'h3C3C);               // C+2
        tick();                       // C+3
        tick();                       // C+4, count now 4
        read_req_i = 1'b1;
        tick();                       // C+5, inside window
        read_req_i = 1'b0;
        chk("R8 viol pulse", read_viol_o, 1);
        chk("R8 deferred oe", oe_o, 0);
        tick();                       // C+6
        chk("R8 viol one cycle", read_viol_o, 0);
        chk("R8 deferred oe c6", oe_o, 0);
        tick();                       // C+7
        tick();                       // C+8
        chk("R8 deferred oe c8", oe_o, 0);
        check_frame(16'h3C3C, 1'b0, "R8 R9 deferred", -1, '0);
    endtask

    task automatic t_midframe();
        load(16'hF00F);
        mode_i = 1'b0; read_req_i = 1'b1;
        check_frame(16'hF00F, 1'b0, "R10 R12 midframe", 6, 16'h0FF0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R11 ignored request", oe_o, 0);
        end
        mode_i = 1'b0;
        read_req_i = 1'b1;
        check_frame(16'h0FF0, 1'b0, "R10 new data next frame", -1, '0);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_daisy();
        t_cascade();
        t_prev_cur();
        t_window();
        t_midframe();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule